// File: doc/BRIEF.md
# Synchronous serial port controller

This block is a serial peripheral master placed on a simple 32-bit register bus. Software sets the frame width, the clock idle level, the sampling edge and the bit rate. It then writes words to a data register, which feeds an eight-entry transmit queue. The shift engine takes one word at a time from that queue. It drives the serial clock and the outgoing data line, and it samples the incoming data line. Every frame it sends produces one received word in an eight-entry receive queue. Software pops that queue by reading the same data register. The chip-select line is not part of the block; a general-purpose output drives it.

The register bus is plain. A write takes effect on the clock edge where `bus_we` is high. Read data depends only on `bus_addr` and is valid in the same cycle. A read of the data register pops the receive queue on the clock edge where `bus_re` is high. Back-pressure is never signalled on the bus. A write to a full transmit queue is discarded. A read of an empty receive queue returns zero. The shift engine waits whenever the receive queue has no room, so no received word is lost. Software watches the status register to avoid both cases.

Register map (byte offsets): 0x000 frame control, 0x004 port enable, 0x008 data, 0x00C status, 0x010 bit-rate prescale. The identification words are at 0xFE0, 0xFE4, 0xFE8 and 0xFEC. Every other address reads as zero.

Top module: `sspi_ctrl`

## Requirements
- R1: After reset the status register (0x00C) reads 0x03. Its bits are: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, bit 4 busy. The frame control register reads 0 after reset.
- R2: The identification words read 0x22 at 0xFE0, 0x10 at 0xFE4, 0x04 at 0xFE8 and 0x00 at 0xFEC. An unmapped address (for example 0x020) reads 0.
- R3: Frame control bits [3:0] hold the frame width minus one. A frame carries that many bits, most significant bit first. Transmit bits above the frame width are ignored.
- R4: Frame control bit 6 sets the idle level of the serial clock. Bit 7 chooses the sampling edge: 0 samples on the leading edge of each clock pulse, with data changing on the trailing edge; 1 samples on the trailing edge, with data changing on the leading edge. Between frames the clock rests at the idle level.
- R5: Each half period of the serial clock lasts max(1, P>>1) * (S+1) system clock cycles. P is the prescale register bits [7:0]; P bit 0 is ignored. S is frame control bits [15:8].
- R6: Port enable register bit 1 enables the port. While the port is disabled, no frame starts, but data register writes still enter the transmit queue.
- R7: When the transmit queue already holds 8 words, a further data register write is dropped, and status bit 1 reads 0.
- R8: Each finished frame pushes the received bits into the receive queue, most significant bit first, right-aligned with zero upper bits. Reads of the data register return the words in arrival order.
- R9: While the receive queue holds 8 words (status bit 3 set), no new frame starts. Shifting resumes once a word is read out.
- R10: A data register read while the receive queue is empty returns 0 and leaves the status unchanged.
- R11: Busy (status bit 4) is high while a frame is shifting, or while the port is enabled and the transmit queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops the receive queue on a data read) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench drives the incoming line with the inverse of the outgoing line. A decoder samples the outgoing line on the edge each mode defines. Together these check that the sent word matches what was queued and that the received word is its bitwise inverse; a swapped bit order or a wrong sampling edge shows up as a mismatch. Asymmetric bytes go out in all four clock modes, and 4-bit and 16-bit frames check width selection and the masking of unused upper bits. A slow-rate frame fixes the half-period length. A disabled-port fill with nine writes, followed by enabling the port without reading, checks the dropped ninth word, the receive-full stall and the busy flag against each other.

// File: rtl/sspi_pkg.sv
package sspi_pkg;
  localparam logic [11:0] A_FRAME = 12'h000;
  localparam logic [11:0] A_ENABLE = 12'h004;
  localparam logic [11:0] A_DATA = 12'h008;
  localparam logic [11:0] A_STAT = 12'h00C;
  localparam logic [11:0] A_PRESC = 12'h010;
  localparam logic [11:0] A_ID0 = 12'hFE0;
  localparam logic [11:0] A_ID1 = 12'hFE4;
  localparam logic [11:0] A_ID2 = 12'hFE8;
  localparam logic [11:0] A_ID3 = 12'hFEC;

  localparam logic [7:0] ID_W0 = 8'h22;
  localparam logic [7:0] ID_W1 = 8'h10;
  localparam logic [7:0] ID_W2 = 8'h04;
  localparam logic [7:0] ID_W3 = 8'h00;

  localparam int POL_BIT = 6;
  localparam int PHA_BIT = 7;
  localparam int EN_BIT = 1;

  typedef struct packed {
    logic busy;
    logic rx_full;
    logic rx_nempty;
    logic tx_nfull;
    logic tx_empty;
  } stat_t;
endpackage

// File: rtl/sspi_fifo.sv
module sspi_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop) rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R7: a push into a full queue leaves the fill level alone
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == $past(cnt)));

  // R10: a pop from an empty queue leaves the fill level alone
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/sspi_baud.sv
module sspi_baud (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [7:0] presc,
  input  logic [7:0] rate,
  output logic       tick
);
  logic [6:0] pc, plim;
  logic [7:0] rc;

  assign plim = (presc[7:1] == 7'd0) ? 7'd0 : presc[7:1] - 7'd1;
  assign tick = run && (pc == plim) && (rc == rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      rc <= '0;
    end else if (!run) begin
      pc <= '0;
      rc <= '0;
    end else if (pc == plim) begin
      pc <= '0;
      rc <= (rc == rate) ? 8'd0 : rc + 8'd1;
    end else begin
      pc <= pc + 7'd1;
    end
  end
endmodule

// File: rtl/sspi_engine.sv
module sspi_engine #(
  parameter int MAXW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [MAXW-1:0]          tx_word,
  input  logic [$clog2(MAXW)-1:0]  width_m1,
  input  logic                     pol,
  input  logic                     pha,
  input  logic                     tick,
  input  logic                     miso,
  output logic                     active,
  output logic                     done,
  output logic [MAXW-1:0]          rx_word,
  output logic                     sclk,
  output logic                     mosi
);
  localparam int WW = $clog2(MAXW);
  localparam int EW = $clog2(2 * MAXW);

  logic [EW-1:0]   cnt, last;
  logic [WW-1:0]   wl;
  logic [MAXW-1:0] shtx, shrx;
  logic            tgl, pol_l, pha_l;
  logic            samp, shev;

  assign last    = EW'({wl, 1'b1});
  assign samp    = pha_l ? cnt[0] : ~cnt[0];
  assign shev    = pha_l ? (~cnt[0] && (cnt != '0)) : cnt[0];
  assign sclk    = active ? (pol_l ^ tgl) : pol;
  assign mosi    = shtx[MAXW-1];
  assign rx_word = shrx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      wl     <= '0;
      shtx   <= '0;
      shrx   <= '0;
      tgl    <= 1'b0;
      pol_l  <= 1'b0;
      pha_l  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          cnt    <= '0;
          tgl    <= 1'b0;
          wl     <= width_m1;
          pol_l  <= pol;
          pha_l  <= pha;
          shtx   <= tx_word << (WW'(MAXW - 1) - width_m1);
          shrx   <= '0;
        end
      end else if (tick) begin
        tgl <= ~tgl;
        if (samp) shrx <= {shrx[MAXW-2:0], miso};
        if (shev) shtx <= {shtx[MAXW-2:0], 1'b0};
        if (cnt == last) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: an even number of clock toggles closes each frame, so the clock is back at rest
  assert_frame_ends_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tgl == 1'b0));

  // R3: the edge counter never runs past two edges per frame bit
  assert_edge_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= last));
endmodule

// File: rtl/sspi_ctrl.sv
module sspi_ctrl
  import sspi_pkg::*;
#(
  parameter int DW = 16,
  parameter int FDEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i
);
  localparam int WW = $clog2(DW);

  logic [15:0]   frame_r;
  logic          en_r;
  logic [7:0]    presc_r;
  logic [DW-1:0] tx_head, rx_head, rx_word;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_push, rx_pop, start;
  logic          active, done, tick;
  stat_t         st;
  logic          unused_wdata;

  assign unused_wdata = ^bus_wdata[31:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_r <= '0;
      en_r    <= 1'b0;
      presc_r <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_FRAME:  frame_r <= bus_wdata[15:0];
        A_ENABLE: en_r    <= bus_wdata[EN_BIT];
        A_PRESC:  presc_r <= bus_wdata[7:0];
        default:  ;
      endcase
    end
  end

  assign tx_push = bus_we && (bus_addr == A_DATA);
  assign rx_pop  = bus_re && (bus_addr == A_DATA) && !rx_empty;
  assign start   = en_r && !tx_empty && !rx_full && !active && !done;

  sspi_fifo #(.W(DW), .DEPTH(FDEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(start),
    .din(bus_wdata[DW-1:0]), .dout(tx_head), .full(tx_full), .empty(tx_empty)
  );

  sspi_fifo #(.W(DW), .DEPTH(FDEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(done), .pop(rx_pop),
    .din(rx_word), .dout(rx_head), .full(rx_full), .empty(rx_empty)
  );

  sspi_baud u_baud (
    .clk(clk), .rst_n(rst_n), .run(active),
    .presc(presc_r), .rate(frame_r[15:8]), .tick(tick)
  );

  sspi_engine #(.MAXW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_head),
    .width_m1(frame_r[WW-1:0]), .pol(frame_r[POL_BIT]), .pha(frame_r[PHA_BIT]),
    .tick(tick), .miso(miso_i), .active(active), .done(done),
    .rx_word(rx_word), .sclk(sclk_o), .mosi(mosi_o)
  );

  always_comb begin
    st.tx_empty  = tx_empty;
    st.tx_nfull  = !tx_full;
    st.rx_nempty = !rx_empty;
    st.rx_full   = rx_full;
    st.busy      = active || (en_r && !tx_empty);
  end

  always_comb begin
    case (bus_addr)
      A_FRAME:  bus_rdata = {16'd0, frame_r};
      A_ENABLE: bus_rdata = {30'd0, en_r, 1'b0};
      A_DATA:   bus_rdata = rx_empty ? 32'd0 : 32'(rx_head);
      A_STAT:   bus_rdata = {27'd0, st};
      A_PRESC:  bus_rdata = {24'd0, presc_r};
      A_ID0:    bus_rdata = {24'd0, ID_W0};
      A_ID1:    bus_rdata = {24'd0, ID_W1};
      A_ID2:    bus_rdata = {24'd0, ID_W2};
      A_ID3:    bus_rdata = {24'd0, ID_W3};
      default:  bus_rdata = 32'd0;
    endcase
  end

  // R9: a finished frame always finds room in the receive queue
  assert_rx_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rx_full);

  // R6: a frame only begins while the port is enabled
  assert_start_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(en_r));

  // R11: busy is reported whenever the shift engine is running
  assert_busy_shift_R11: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> st.busy);
endmodule

// File: tb/sspi_ctrl_tb_top.sv
module sspi_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk_o, mosi_o, miso_i;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] exp_tx[$];
  logic [15:0] exp_rx[$];
  bit   mon_on = 0;
  bit   m_pol = 0, m_pha = 0;
  int   m_w = 8;
  int   m_cnt = 0;
  logic [15:0] m_word = '0;

  assign miso_i = ~mosi_o;

  always #5 clk = ~clk;

  sspi_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wmask(input int w);
    return 16'((32'd1 << w) - 1);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic send(input logic [15:0] w);
    exp_tx.push_back(w & wmask(m_w));
    exp_rx.push_back(~w & wmask(m_w));
    wr(12'h008, {16'd0, w});
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(12'h00C, s);
      if (s[4] == 1'b0) break;
    end
  endtask

  task automatic drain(input int n, input string tag);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      rd(12'h008, d);
      check(tag, d, (exp_rx.size() > 0) ? {16'd0, exp_rx.pop_front()} : 32'hDEAD);
    end
  endtask

  task automatic set_mode(input bit pol, input bit pha, input int w, input logic [7:0] rate);
    mon_on = 0;
    m_pol = pol; m_pha = pha; m_w = w; m_cnt = 0;
    wr(12'h000, {16'd0, rate, pha, pol, 2'b00, 4'(w - 1)});
    @(negedge clk);
    mon_on = 1;
  endtask

  // monitor: decodes the outgoing line on the sampling edge of the current mode (R3, R4)
  initial begin
    forever begin
      @(posedge sclk_o or negedge sclk_o);
      if (mon_on) begin
        if (m_pha ? (sclk_o == m_pol) : (sclk_o != m_pol)) begin
          m_word = {m_word[14:0], mosi_o};
          m_cnt++;
          if (m_cnt == m_w) begin
            m_cnt = 0;
            check("R3 R4 serial word", {16'd0, m_word & wmask(m_w)},
                  (exp_tx.size() > 0) ? {16'd0, exp_tx.pop_front()} : 32'hDEAD);
          end
        end
      end
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    realtime t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(12'h00C, d); check("R1 reset status", d, 32'h03);
    rd(12'h000, d); check("R1 reset frame control", d, 32'h0);
    rd(12'hFE0, d); check("R2 id0", d, 32'h22);
    rd(12'hFE4, d); check("R2 id1", d, 32'h10);
    rd(12'hFE8, d); check("R2 id2", d[3:0], 32'h4);
    rd(12'hFEC, d); check("R2 id3", d, 32'h00);
    rd(12'h020, d); check("R2 unmapped", d, 32'h0);
    rd(12'h008, d); check("R10 empty read", d, 32'h0);
    rd(12'h00C, d); check("R10 status after empty read", d, 32'h03);

    wr(12'h010, 32'd2);
    wr(12'h004, 32'h2);
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0], 8, 8'd0);
      send(16'h00A5); send(16'h003C); send(16'h0081);
      wait_idle();
      check("R4 idle clock level", {31'd0, sclk_o}, {31'd0, m_pol});
      drain(3, "R8 received word mode");
    end

    set_mode(0, 0, 16, 8'd0);
    send(16'hBEEF); send(16'h1234);
    wait_idle();
    drain(2, "R8 received 16-bit");
    set_mode(0, 1, 4, 8'd0);
    send(16'h00F9); send(16'h0006);
    wait_idle();
    drain(2, "R3 received 4-bit masked");

    set_mode(0, 0, 8, 8'd2);
    wr(12'h010, 32'd4);
    send(16'h0055);
    rd(12'h00C, d); check("R11 busy while shifting", {31'd0, d[4]}, 32'd1);
    @(posedge sclk_o); t0 = $realtime;
    @(negedge sclk_o); t1 = $realtime;
    check("R5 half period ns", 32'(int'(t1 - t0)), 32'd60);
    wait_idle();
    drain(1, "R8 received slow");

    set_mode(0, 0, 8, 8'd0);
    wr(12'h010, 32'd2);
    wr(12'h004, 32'h0);
    for (int i = 0; i < 8; i++) send(16'(8'h11 * (i + 1)));
    wr(12'h008, 32'h00FF);
    repeat (50) @(negedge clk);
    rd(12'h00C, d); check("R6 R7 disabled and full", d, 32'h00);
    check("R6 no frame while disabled", 32'(exp_tx.size()), 32'd8);
    wr(12'h004, 32'h2);
    repeat (300) @(negedge clk);
    rd(12'h00C, d); check("R9 receive queue full", d, 32'h0F);
    send(16'h0077);
    repeat (100) @(negedge clk);
    rd(12'h00C, d); check("R9 R11 stalled on full receive", d, 32'h1E);
    check("R9 stalled frame not sent", 32'(exp_tx.size()), 32'd1);
    drain(1, "R8 first of full queue");
    wait_idle();
    drain(8, "R7 R8 rest of queue");
    rd(12'h00C, d); check("R1 final status", d, 32'h03);
    check("R7 dropped word never sent", 32'(exp_tx.size()), 32'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule